// File: doc/BRIEF.md
# Pseudo-Random Test Word Monitor

This block watches a stream of 16-bit converter samples that were captured while the converter runs a built-in test mode, and decides whether the stream matches what that test mode should produce. Three check modes can be chosen: a 9-stage pseudo-random sequence, a 23-stage pseudo-random sequence, and a fixed word held on an input port. The pseudo-random streams follow the usual feedback polynomials. On the wire, however, bit 15 of every word is inverted, and the monitor removes that inversion before it compares.

In the pseudo-random modes the monitor needs no seed from outside. While it is out of sync it keeps loading the received words into a history register and predicts each next word from that history. Once it has seen enough correct predictions in a row it declares lock. From then on it runs its generator on its own predictions, so a single bad word raises an error without spoiling the words that follow. A long run of bad words makes it give up the lock and learn the sequence again. Two registered outputs carry the result to software: an out-of-sync status and a sticky error flag. A clear input drops the error flag and restarts acquisition.

Top module: `pn_word_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_of_sync` is 1 and `err_flag` is 0.
- R2: With `mode` = 2'b00, the expected bit stream follows b[k] = b[k-5] XOR b[k-9]. Each word carries 16 consecutive bits, the earliest in bit 15, and the value on the wire has bit 15 inverted.
- R3: With `mode` = 2'b01, the expected bit stream follows b[k] = b[k-18] XOR b[k-23]. Words are packed and inverted as in R2.
- R4: While out of sync, each valid sample with bit 15 restored is loaded as generator history. `out_of_sync` falls on the clock edge of the 8th valid sample in a row that matches the prediction. A mismatch in a pseudo-random mode does not set `err_flag` while out of sync.
- R5: While in sync, a valid sample that differs from the prediction sets `err_flag`. The flag stays set until `clr`. The generator advances on its own prediction, so the following correct words still match.
- R6: While in sync, 8 consecutive mismatching valid samples raise `out_of_sync` on the edge of the 8th, and acquisition starts again (R4).
- R7: With `mode[1]` = 1 (fixed-word mode), each valid sample is compared raw with `pat_value`, with no bit inverted. Any difference sets `err_flag`, whether or not the monitor is in sync. Sync is gained and lost on the counts of R4 and R6.
- R8: `clr` high at an edge leaves `err_flag` = 0 and `out_of_sync` = 1 after that edge, even if a mismatching sample arrives in the same cycle.
- R9: A change of `mode` from one cycle to the next leaves `out_of_sync` = 1 after that edge and clears both run counters.
- R10: Cycles with `in_valid` low change neither the outputs nor the generator history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Captured sample |
| mode | input | 2 | 00: 9-stage sequence, 01: 23-stage sequence, 1x: fixed word |
| pat_value | input | 16 | Expected word in fixed-word mode |
| clr | input | 1 | Clears the error flag and restarts acquisition |
| out_of_sync | output | 1 | 1 while the monitor has no lock |
| err_flag | output | 1 | Sticky mismatch flag |

## Verification
The case that needs care is a status clear that lands in the same cycle as a mismatching sample while the monitor is locked. The sticky-flag logic would set `err_flag` and the clear would drop it, and the clear has to win. The bench provokes this by sending a deliberately corrupted word with `clr` raised on that cycle. It then expects the flag low and the status out of sync after that edge. Afterwards it expects the monitor to lock again within nine clean words without raising the flag, because the corrupted word entered the history.

// File: rtl/pnm_pkg.sv
package pnm_pkg;
  typedef enum logic [1:0] {
    MODE_PN9  = 2'b00,
    MODE_PN23 = 2'b01,
    MODE_FIX  = 2'b10,
    MODE_FIX2 = 2'b11
  } pnm_mode_e;

  localparam int PN9_LEN  = 9;
  localparam int PN9_TAP  = 5;
  localparam int PN23_LEN = 23;
  localparam int PN23_TAP = 18;

  function automatic logic is_fixed(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/pnm_predict.sv
module pnm_predict #(
  parameter int W   = 16,
  parameter int HW  = 32,
  parameter int LEN = 9,
  parameter int TAP = 5
) (
  input  logic [HW-1:0] hist,
  output logic [W-1:0]  word
);
  // hist[0] is the most recent bit; extend the stream by W bits
  function automatic logic [W-1:0] next_word(input logic [HW-1:0] h);
    logic [HW+W-1:0] seq;
    logic [W-1:0]    r;
    seq = '0;
    r   = '0;
    for (int i = 0; i < HW; i++) seq[i] = h[HW-1-i];
    for (int i = HW; i < HW + W; i++) seq[i] = seq[i-LEN] ^ seq[i-TAP];
    for (int i = 0; i < W; i++) r[W-1-i] = seq[HW+i];
    return r;
  endfunction

  always_comb word = next_word(hist);

  initial begin
    assert (LEN <= HW && TAP < LEN) else $error("predictor taps exceed history");
  end
endmodule

// File: rtl/pnm_history.sv
module pnm_history #(
  parameter int W  = 16,
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  din,
  output logic [HW-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)       hist <= '0;
    else if (load) hist <= {hist[HW-W-1:0], din};
  end
endmodule

// File: rtl/pnm_sync.sv
module pnm_sync #(
  parameter int SYNC_LEN = 8,
  parameter int LOSS_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic hit,
  input  logic resync,
  input  logic clr,
  input  logic fixed_mode,
  output logic oos_q,
  output logic err_q
);
  localparam int CMAX = (SYNC_LEN > LOSS_LEN) ? SYNC_LEN : LOSS_LEN;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_LEN - 1);
  localparam logic [CW-1:0] LOSS_LAST = CW'(LOSS_LEN - 1);

  logic [CW-1:0] good_run;
  logic [CW-1:0] bad_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      oos_q    <= 1'b1;
      err_q    <= 1'b0;
      good_run <= '0;
      bad_run  <= '0;
    end else if (resync) begin
      oos_q    <= 1'b1;
      good_run <= '0;
      bad_run  <= '0;
      if (clr) err_q <= 1'b0;
    end else if (valid) begin
      if (!hit && (fixed_mode || !oos_q)) err_q <= 1'b1;
      if (oos_q) begin
        if (!hit) begin
          good_run <= '0;
        end else if (good_run == SYNC_LAST) begin
          oos_q    <= 1'b0;
          good_run <= '0;
          bad_run  <= '0;
        end else begin
          good_run <= good_run + 1'b1;
        end
      end else begin
        if (hit) begin
          bad_run <= '0;
        end else if (bad_run == LOSS_LAST) begin
          oos_q    <= 1'b1;
          bad_run  <= '0;
          good_run <= '0;
        end else begin
          bad_run <= bad_run + 1'b1;
        end
      end
    end
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (oos_q && !err_q));
  p_gain_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(oos_q) |-> $past(valid && hit && !resync));
  p_err_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(valid && !hit && !resync));
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr) |=> err_q);
  p_loss_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(oos_q) |-> $past(resync || (valid && !hit)));
  p_clr_wins_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!err_q && oos_q));
endmodule

// File: rtl/pn_word_monitor.sv
module pn_word_monitor #(
  parameter int W        = 16,
  parameter int SYNC_LEN = 8,
  parameter int LOSS_LEN = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic [1:0]   mode,
  input  logic [W-1:0] pat_value,
  input  logic         clr,
  output logic         out_of_sync,
  output logic         err_flag
);
  import pnm_pkg::*;

  localparam int HW = 2 * W;
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [1:0]    mode_q;
  logic          mode_chg;
  logic          resync;
  logic [W-1:0]  rx_word;
  logic [HW-1:0] hist;
  logic [W-1:0]  pred [2];
  logic [W-1:0]  pred_sel;
  logic          hit;
  logic          hist_load;
  logic [W-1:0]  hist_din;
  logic          oos_i;
  logic          err_i;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_PN9;
    else     mode_q <= mode;
  end

  assign mode_chg = (mode != mode_q);
  assign resync   = mode_chg || clr;
  assign rx_word  = in_data ^ TOP_BIT;

  for (genvar g = 0; g < 2; g++) begin : g_pred
    localparam int LEN_G = (g == 0) ? PN9_LEN : PN23_LEN;
    localparam int TAP_G = (g == 0) ? PN9_TAP : PN23_TAP;
    pnm_predict #(.W(W), .HW(HW), .LEN(LEN_G), .TAP(TAP_G)) u_pred (
      .hist (hist),
      .word (pred[g])
    );
  end

  assign pred_sel = pred[mode[0]];
  assign hit = is_fixed(mode) ? (in_data == pat_value) : (rx_word == pred_sel);

  assign hist_load = in_valid;
  assign hist_din  = (oos_i || resync) ? rx_word : pred_sel;

  pnm_history #(.W(W), .HW(HW)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .load (hist_load),
    .din  (hist_din),
    .hist (hist)
  );

  pnm_sync #(.SYNC_LEN(SYNC_LEN), .LOSS_LEN(LOSS_LEN)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .valid      (in_valid),
    .hit        (hit),
    .resync     (resync),
    .clr        (clr),
    .fixed_mode (is_fixed(mode)),
    .oos_q      (oos_i),
    .err_q      (err_i)
  );

  assign out_of_sync = oos_i;
  assign err_flag    = err_i;

  p_mode_change_r9: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> out_of_sync);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clr && !mode_chg) |=> ($stable(out_of_sync) && $stable(err_flag) && $stable(hist)));
  p_pn_err_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_fixed(mode) && out_of_sync && !err_flag && !resync) |=> !err_flag);
endmodule

// File: tb/pn_word_monitor_tb_top.sv
module pn_word_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] pat_value = 16'h3C5A;
  logic        clr = 1'b0;
  logic        out_of_sync;
  logic        err_flag;

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] bh;
  int tap_len = 9;
  int tap_fb = 5;
  logic [15:0] w;

  always #4 clk = ~clk;

  pn_word_monitor dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .mode(mode), .pat_value(pat_value), .clr(clr),
    .out_of_sync(out_of_sync), .err_flag(err_flag)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // next 16 sequence bits, earliest in bit 15, raw (no inversion)
  task automatic gen(output logic [15:0] r);
    for (int k = 0; k < 16; k++) begin
      logic nb;
      nb = bh[tap_len-1] ^ bh[tap_fb-1];
      bh = {bh[62:0], nb};
      r[15-k] = nb;
    end
  endtask

  task automatic put(input logic [15:0] d, input logic v, input logic c);
    @(negedge clk);
    in_data = d; in_valid = v; clr = c;
    @(posedge clk);
    #2;
    in_valid = 1'b0; clr = 1'b0;
  endtask

  task automatic good(int n);
    for (int i = 0; i < n; i++) begin
      gen(w);
      put(w ^ 16'h8000, 1'b1, 1'b0);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bh = 64'h1F3;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset oos", {15'd0, out_of_sync}, 16'd1);
    chk("R1 reset err", {15'd0, err_flag}, 16'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    chk("R1 after reset oos", {15'd0, out_of_sync}, 16'd1);

    // R2/R4: first word mismatches the empty history, 2..9 match
    good(8);
    chk("R4 still oos after 8", {15'd0, out_of_sync}, 16'd1);
    chk("R4 no err while oos", {15'd0, err_flag}, 16'd0);
    good(1);
    chk("R2 lock after 9 pn9 words", {15'd0, out_of_sync}, 16'd0);
    good(40);
    chk("R2 locked pn9 run oos", {15'd0, out_of_sync}, 16'd0);
    chk("R2 locked pn9 run err", {15'd0, err_flag}, 16'd0);

    // R5: single bad word, then good words still match
    gen(w); put((w ^ 16'h8000) ^ 16'h0001, 1'b1, 1'b0);
    chk("R5 err after bad word", {15'd0, err_flag}, 16'd1);
    chk("R5 lock kept", {15'd0, out_of_sync}, 16'd0);
    good(5);
    chk("R5 err sticky", {15'd0, err_flag}, 16'd1);

    // R8: clear with a good word, regain in 8 (history aligned)
    gen(w); put(w ^ 16'h8000, 1'b1, 1'b1);
    chk("R8 clr err", {15'd0, err_flag}, 16'd0);
    chk("R8 clr oos", {15'd0, out_of_sync}, 16'd1);
    good(7);
    chk("R4 oos after 7 aligned", {15'd0, out_of_sync}, 16'd1);
    good(1);
    chk("R4 lock after 8 aligned", {15'd0, out_of_sync}, 16'd0);

    // R10: invalid garbage ignored
    put(16'hDEAD, 1'b0, 1'b0);
    chk("R10 idle err", {15'd0, err_flag}, 16'd0);
    chk("R10 idle oos", {15'd0, out_of_sync}, 16'd0);
    good(3);
    chk("R10 history untouched", {15'd0, err_flag}, 16'd0);

    // R8: clear and mismatch in the same cycle
    gen(w); put((w ^ 16'h8000) ^ 16'h0001, 1'b1, 1'b1);
    chk("R8 clr beats miss err", {15'd0, err_flag}, 16'd0);
    chk("R8 clr beats miss oos", {15'd0, out_of_sync}, 16'd1);
    good(12);
    chk("R8 relock after clr+miss", {15'd0, out_of_sync}, 16'd0);
    chk("R8 no err during relock", {15'd0, err_flag}, 16'd0);

    // R6: loss after 8 bad words
    for (int i = 0; i < 7; i++) begin
      gen(w); put((w ^ 16'h8000) ^ 16'h0100, 1'b1, 1'b0);
    end
    chk("R6 lock kept after 7 bad", {15'd0, out_of_sync}, 16'd0);
    chk("R6 err set", {15'd0, err_flag}, 16'd1);
    gen(w); put((w ^ 16'h8000) ^ 16'h0100, 1'b1, 1'b0);
    chk("R6 lock lost after 8 bad", {15'd0, out_of_sync}, 16'd1);
    good(7);
    chk("R6 reacquire not yet", {15'd0, out_of_sync}, 16'd1);
    good(1);
    chk("R6 reacquired", {15'd0, out_of_sync}, 16'd0);

    // R2: stream without the bit-15 inversion never locks
    put(16'h0, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      gen(w); put(w, 1'b1, 1'b0);
    end
    chk("R2 raw stream stays oos", {15'd0, out_of_sync}, 16'd1);
    chk("R2 raw stream no err", {15'd0, err_flag}, 16'd0);

    // R3: 23-stage mode
    mode = 2'b01; tap_len = 23; tap_fb = 18; bh = 64'h5A5A5A;
    put(16'h0, 1'b0, 1'b0);
    chk("R9 mode change oos", {15'd0, out_of_sync}, 16'd1);
    good(10);
    chk("R3 pn23 lock within 10", {15'd0, out_of_sync}, 16'd0);
    good(30);
    chk("R3 pn23 run err", {15'd0, err_flag}, 16'd0);
    gen(w); put((w ^ 16'h8000) ^ 16'h4000, 1'b1, 1'b0);
    chk("R3 pn23 bad word err", {15'd0, err_flag}, 16'd1);
    good(2);
    chk("R3 pn23 still locked", {15'd0, out_of_sync}, 16'd0);

    // R9 + R7: change to fixed word while locked, clear in same idle cycle
    mode = 2'b10;
    put(16'h0, 1'b0, 1'b1);
    chk("R9 change while locked", {15'd0, out_of_sync}, 16'd1);
    chk("R8 clr with mode change", {15'd0, err_flag}, 16'd0);
    for (int i = 0; i < 7; i++) put(16'h3C5A, 1'b1, 1'b0);
    chk("R7 fixed oos after 7", {15'd0, out_of_sync}, 16'd1);
    put(16'h3C5A, 1'b1, 1'b0);
    chk("R7 fixed lock after 8", {15'd0, out_of_sync}, 16'd0);
    chk("R7 fixed no err", {15'd0, err_flag}, 16'd0);
    put(16'h3C5A ^ 16'h8000, 1'b1, 1'b0);
    chk("R7 no inversion in fixed mode", {15'd0, err_flag}, 16'd1);
    put(16'h0, 1'b0, 1'b1);
    put(16'h1234, 1'b1, 1'b0);
    chk("R7 err while oos fixed", {15'd0, err_flag}, 16'd1);
    chk("R7 oos fixed", {15'd0, out_of_sync}, 16'd1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule